// File: doc/BRIEF.md
# Thermometer-Merge Six-Input Population Counter

This block counts how many of six independent input bits are set and returns that count as an unsigned 3-bit number from 0 to 6. It is meant to serve as a 6:3 compressor cell in partial-product reduction trees and in similar multi-operand adders. It does not build the sum from full-adder chains. Instead it sorts the set bits of each half of the input into a packed run of ones, which is a thermometer code. It then merges the two runs into one 6-bit run using a symmetric OR-of-ANDs network. A final decoder turns the run into binary using only AND, OR and inversion terms, so no exclusive-OR gate appears anywhere between an input and the count.

The counting logic is purely combinational. The top level places it between an input register and an output register on one clock, which makes the cell easy to time in isolation. Both registers clear to zero on a synchronous active-high reset.

Top module: `sym_stack_popcnt`

## Requirements
- R1: For every one of the 64 input patterns, `count_o` equals the number of set bits in the `bits_i` value that produced it.
- R2: Each half (`bits_i[2:0]` and `bits_i[5:3]`) is packed into a 3-bit thermometer code. Bit 0 is set when at least one input of the half is set, bit 1 when at least two are set, and bit 2 when all three are set.
- R3: The two 3-bit codes merge into a 6-bit thermometer code. Bit k of that code is set exactly when the total number of set inputs is greater than k.
- R4: A value applied on `bits_i` before a rising edge of `clk` appears on `count_o` after the second rising edge, counting from that first edge (two register stages). `count_o` keeps its previous value until then.
- R5: While `rst` is high at a rising edge, both the input register and `count_o` clear to 0, whatever `bits_i` holds.
- R6: The extreme patterns give the extreme counts: all-zero inputs give 0 and all-one inputs give 6. The count does not depend on which positions hold the set bits, so `6'b000111` and `6'b111000` both give 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input and output registers |
| rst | input | 1 | Synchronous active-high reset |
| bits_i | input | 6 | Six independent bits to be counted |
| count_o | output | 3 | Registered unsigned count of set bits, 0 to 6 |

## Verification
The counter receives all 64 patterns twice. The first pass runs in ascending binary order, where many bits flip at once across carries. The second pass runs in Gray-code order, where one bit changes per step, so each result differs from the one before it by exactly one. Patterns with set bits confined to a single half exercise only one packing stage. Patterns split across both halves exercise every AND term of the merge network. All-zero, all-one and mirrored half patterns separate position dependence from true counting. A held step from 0 to 6 and a reset asserted with all inputs set show the two-stage latency and the clearing of both registers.

// File: rtl/sym_stack_pkg.sv
package sym_stack_pkg;
  localparam int N_IN  = 6;
  localparam int GRP_W = 3;
  localparam int CNT_W = $clog2(N_IN + 1);
endpackage

// File: rtl/tri_stacker.sv
module tri_stacker (
  input  logic [2:0] in_i,
  output logic [2:0] stk_o
);
  always_comb begin
    stk_o[0] = in_i[0] | in_i[1] | in_i[2];
    stk_o[1] = (in_i[0] & in_i[1]) | (in_i[1] & in_i[2]) | (in_i[0] & in_i[2]);
    stk_o[2] = in_i[0] & in_i[1] & in_i[2];
  end
endmodule

// File: rtl/stack_merger.sv
module stack_merger #(
  parameter int A_W = 3,
  parameter int B_W = 3,
  localparam int M_W = A_W + B_W
) (
  input  logic [A_W-1:0] x_i,
  input  logic [B_W-1:0] y_i,
  output logic [M_W-1:0] m_o
);
  always_comb begin
    m_o = '0;
    for (int i = 0; i < A_W; i++) m_o[i] = m_o[i] | x_i[i];
    for (int j = 0; j < B_W; j++) m_o[j] = m_o[j] | y_i[j];
    for (int i = 0; i < A_W; i++) begin
      for (int j = 0; j < B_W; j++) begin
        m_o[i+j+1] = m_o[i+j+1] | (x_i[i] & y_i[j]);
      end
    end
  end
endmodule

// File: rtl/stack_decoder.sv
module stack_decoder #(
  parameter int N = 6,
  localparam int C_W = $clog2(N + 1)
) (
  input  logic [N-1:0]   t_i,
  output logic [C_W-1:0] cnt_o
);
  logic [N:0] tp;
  logic       exact;
  always_comb begin
    tp    = {1'b0, t_i};
    cnt_o = '0;
    exact = 1'b0;
    for (int k = 1; k <= N; k++) begin
      exact = tp[k-1] & ~tp[k];
      for (int b = 0; b < C_W; b++) begin
        if (((k >> b) & 1) == 1) cnt_o[b] = cnt_o[b] | exact;
      end
    end
  end
endmodule

// File: rtl/sym_stack_popcnt.sv
module sym_stack_popcnt
  import sym_stack_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  bits_i,
  output logic [CNT_W-1:0] count_o
);
  logic [N_IN-1:0]  in_q;
  logic [GRP_W-1:0] stk_lo, stk_hi;
  logic [N_IN-1:0]  stk_all;
  logic [CNT_W-1:0] cnt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      count_o <= '0;
    end else begin
      in_q    <= bits_i;
      count_o <= cnt_d;
    end
  end

  tri_stacker u_stk_lo (.in_i(in_q[GRP_W-1:0]),      .stk_o(stk_lo));
  tri_stacker u_stk_hi (.in_i(in_q[N_IN-1:GRP_W]),   .stk_o(stk_hi));

  stack_merger #(.A_W(GRP_W), .B_W(GRP_W)) u_merge (
    .x_i(stk_lo), .y_i(stk_hi), .m_o(stk_all)
  );

  stack_decoder #(.N(N_IN)) u_dec (.t_i(stk_all), .cnt_o(cnt_d));
endmodule

// File: rtl/sym_stack_popcnt_chk.sv
module sym_stack_popcnt_chk
  import sym_stack_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [N_IN-1:0]  in_q,
  input logic [GRP_W-1:0] stk_lo,
  input logic [GRP_W-1:0] stk_hi,
  input logic [N_IN-1:0]  stk_all,
  input logic [CNT_W-1:0] count_o
);
  a_r2_lo_thermo: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, stk_lo} + 4'd1) & {1'b0, stk_lo}) == 4'd0) &&
    ($countones(stk_lo) == $countones(in_q[GRP_W-1:0])));

  a_r2_hi_thermo: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, stk_hi} + 4'd1) & {1'b0, stk_hi}) == 4'd0) &&
    ($countones(stk_hi) == $countones(in_q[N_IN-1:GRP_W])));

  a_r3_merged_thermo: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, stk_all} + 7'd1) & {1'b0, stk_all}) == 7'd0) &&
    ($countones(stk_all) == $countones(in_q)));

  a_r1_count_matches: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (count_o == CNT_W'($countones($past(in_q)))));

  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (count_o == '0) && (in_q == '0));

  a_r6_range: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_W'(N_IN));
endmodule

bind sym_stack_popcnt sym_stack_popcnt_chk chk_i (
  .clk(clk), .rst(rst), .in_q(in_q), .stk_lo(stk_lo), .stk_hi(stk_hi),
  .stk_all(stk_all), .count_o(count_o)
);

// File: tb/sym_stack_popcnt_tb_top.sv
module sym_stack_popcnt_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] bits = '0;
  logic [2:0] count;
  logic       drv_valid = 1'b0;
  logic [1:0] vpipe = '0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sym_stack_popcnt dut_i (.clk(clk), .rst(rst), .bits_i(bits), .count_o(count));

  function automatic int ones(logic [5:0] v);
    int c = 0;
    for (int i = 0; i < 6; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] p, string req);
    @(negedge clk);
    bits = p;
    drv_valid = 1'b1;
    exp_q.push_back(ones(p));
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    drv_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) vpipe <= {vpipe[0], drv_valid};

  // monitor: pops the scoreboard when a result is due
  always @(negedge clk) begin
    if (vpipe[1]) begin
      if (exp_q.size() == 0) begin
        check("R1 underflow", 1, 0);
      end else begin
        string t;
        int e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(count), e);
      end
    end
  end

  initial begin
    #1000000;
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bits = 6'h3F;
    repeat (3) @(negedge clk);
    check("R5 reset with all inputs high", int'(count), 0);
    rst = 1'b0;
    bits = '0;
    repeat (3) @(negedge clk);
    check("R5 idle after reset", int'(count), 0);
    // R4 latency step 0 -> 6
    bits = 6'h3F;
    @(negedge clk);
    check("R4 unchanged after one edge", int'(count), 0);
    @(negedge clk);
    check("R4 result after two edges", int'(count), 6);
    bits = '0;
    repeat (3) @(negedge clk);
    // R6 extremes and position independence
    drive(6'h00, "R6 all zero");
    drive(6'h3F, "R6 all one");
    drive(6'b000111, "R6 low half full");
    drive(6'b111000, "R6 high half full");
    // R2 single-half patterns
    for (int i = 0; i < 8; i++) drive(6'(i), "R2 low half only");
    for (int i = 0; i < 8; i++) drive(6'(i << 3), "R2 high half only");
    // R1 exhaustive ascending, R3 both halves through merge
    for (int i = 0; i < 64; i++) drive(6'(i), "R1 ascending sweep");
    for (int i = 0; i < 64; i++) drive(6'(i ^ (i >> 1)), "R3 gray sweep");
    idle();
    check("R1 scoreboard drained", exp_q.size(), 0);
    // R5 reset mid-stream with inputs set
    bits = 6'h3F;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 reset clears output", int'(count), 0);
    rst = 1'b0;
    bits = '0;
    repeat (3) @(negedge clk);
    check("R5 cleared input register", int'(count), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule